// File: doc/BRIEF.md
# MDIO PHY Management Responder

This block sits on the PHY side of the two-wire management bus and answers the station that drives the management clock. The clock and data pins are oversampled with the chip's own system clock. The block hunts for a run of ones on the data line. Once enough ones have arrived and the start pattern follows, it shifts in a twelve-bit header. The header carries the access type, the device address and the register index.

The block takes part in a frame only when the opcode is read or write and the device address equals a strap input. Up to 32 devices can share one bus this way. A write fills one of the internal 16-bit registers, and only once the last data bit has arrived. A read takes over the shared line in the second turnaround slot and shifts the addressed register out most significant bit first. The line is then released. Every register is visible on a flat parallel output, so the PHY logic around the block can use the settings directly.

Top module: `mgmt_phy_responder`

## Requirements
- R1: A frame is accepted only after at least PREAMBLE_BITS consecutive ones sampled on rising management-clock edges, followed by the start pattern 0 then 1. Any 0 seen before the run is complete restarts the count, and a frame behind a short or broken run is ignored.
- R2: After the start pattern, the header is taken MSB first on rising edges: 2 opcode bits, then 5 device-address bits, then 5 register-index bits.
- R3: The block responds only when the header's device address equals `phy_addr`. On a mismatch, the rest of the frame is skipped, `mdio_oe` stays 0 and no register changes.
- R4: Opcode 2'b01 is a write and 2'b10 is a read. Opcodes 2'b00 and 2'b11 are ignored in the same way as an address mismatch.
- R5: On a read, `mdio_oe` is 0 during the first turnaround bit. During the second turnaround bit it is 1 with `mdio_o` at 0. The 16 data bits follow MSB first, each driven after a rising edge. `mdio_oe` returns to 0 after the rising edge that ends the last data bit.
- R6: `mdio_o` and `mdio_oe` change only in response to a rising management-clock edge. They settle within SYNC_STAGES+2 system-clock cycles of it, far inside the 300 ns window.
- R7: A write changes the addressed register only after the sixteenth data bit. All 16 bits then appear at once on `reg_q[16*index +: 16]`.
- R8: Once a frame ends, the block searches for a preamble again. A start pattern sent straight after a frame, with no new preamble, is ignored.
- R9: Reset clears every register to 16'h0000 and releases the line (`mdio_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the shared data line |
| phy_addr | input | 5 | Strapped device address |
| mdio_o | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Drive enable for the data line (1 = drive) |
| reg_q | output | NREG*16 | All registers, register k at bits 16k+15 down to 16k |

## Verification
The bench builds the block with NREG=32 and PREAMBLE_BITS=32, so register indices 0 and 31 and the exact 31-versus-32 preamble boundary can be tested. SYNC_STAGES=3 is one deeper than the default. This exercises the longest turnaround latency the bench's eight-cycle half period has to absorb, with drive checked in the right slot. The strap is held at 5'h0B, so frames sent to a neighbouring address of 5'h0A show that the block stays off the line.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int DATA_W   = 16;
   localparam int ADDR_W   = 5;
   localparam int OP_W     = 2;
   localparam int HDR_BITS = OP_W + 2 * ADDR_W;
   localparam int SKIP_BITS = 2 + DATA_W;

   localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
   localparam logic [OP_W-1:0] OP_READ  = 2'b10;

   typedef enum logic [2:0] {
      SQ_HUNT,
      SQ_START,
      SQ_HDR,
      SQ_TURN,
      SQ_DATA,
      SQ_SKIP
   } seq_state_t;
endpackage

// File: rtl/mgmt_edge_sync.sv
module mgmt_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_i,
   input  logic mdio_i,
   output logic rise_o,
   output logic bit_o
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] mdc_sr;
   logic [SYNC_STAGES-1:0] dat_sr;
   logic                   mdc_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_sr   <= '0;
         dat_sr   <= '1;
         mdc_last <= 1'b0;
      end else begin
         mdc_sr   <= {mdc_sr[TOP-1:0], mdc_i};
         dat_sr   <= {dat_sr[TOP-1:0], mdio_i};
         mdc_last <= mdc_sr[TOP];
      end
   end

   assign rise_o = mdc_sr[TOP] & ~mdc_last;
   assign bit_o  = dat_sr[TOP];
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
   import mgmt_pkg::*;
#(
   parameter int NREG = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic [NREG*DATA_W-1:0] regs_flat
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
            q <= wr_data;
         end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_addr == ADDR_W'(i)) begin
            rd_data = regs_flat[i*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import mgmt_pkg::*;
#(
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              bit_i,
   input  logic [ADDR_W-1:0] strap,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] reg_idx,
   output logic [OP_W-1:0]   op_cur,
   output logic [ADDR_W-1:0] dev_cur,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int CNT_MAX = (PREAMBLE_BITS > SKIP_BITS) ? PREAMBLE_BITS : SKIP_BITS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   seq_state_t          state;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-1:0] hdr;
   logic [HDR_BITS-1:0] hdr_nx;
   logic [DATA_W-1:0]   shreg;
   logic                hdr_ok;
   logic                is_read;

   assign hdr_nx  = {hdr[HDR_BITS-2:0], bit_i};
   assign hdr_ok  = (hdr_nx[HDR_BITS-1 -: OP_W] == OP_WRITE || hdr_nx[HDR_BITS-1 -: OP_W] == OP_READ)
                    && (hdr_nx[2*ADDR_W-1 -: ADDR_W] == strap);
   assign op_cur  = hdr[HDR_BITS-1 -: OP_W];
   assign dev_cur = hdr[2*ADDR_W-1 -: ADDR_W];
   assign reg_idx = hdr[ADDR_W-1:0];
   assign is_read = (op_cur == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_HUNT;
         cnt     <= '0;
         hdr     <= '0;
         shreg   <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (rise) begin
            case (state)
               SQ_HUNT: begin
                  if (bit_i) begin
                     if (cnt < CNT_W'(PREAMBLE_BITS)) cnt <= cnt + 1'b1;
                  end else begin
                     if (cnt == CNT_W'(PREAMBLE_BITS)) state <= SQ_START;
                     cnt <= '0;
                  end
               end
               SQ_START: begin
                  cnt   <= '0;
                  state <= bit_i ? SQ_HDR : SQ_HUNT;
               end
               SQ_HDR: begin
                  hdr <= hdr_nx;
                  if (cnt == CNT_W'(HDR_BITS - 1)) begin
                     cnt   <= '0;
                     state <= hdr_ok ? SQ_TURN : SQ_SKIP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SQ_TURN: begin
                  if (cnt == '0) begin
                     cnt <= CNT_W'(1);
                     if (is_read) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                     end
                  end else begin
                     cnt   <= '0;
                     state <= SQ_DATA;
                     if (is_read) begin
                        mdio_o <= rd_data[DATA_W-1];
                        shreg  <= {rd_data[DATA_W-2:0], 1'b0};
                     end
                  end
               end
               SQ_DATA: begin
                  if (is_read) begin
                     mdio_o <= shreg[DATA_W-1];
                     shreg  <= {shreg[DATA_W-2:0], 1'b0};
                  end else begin
                     shreg <= {shreg[DATA_W-2:0], bit_i};
                  end
                  if (cnt == CNT_W'(DATA_W - 1)) begin
                     cnt     <= '0;
                     state   <= SQ_HUNT;
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b0;
                     if (!is_read) begin
                        wr_en   <= 1'b1;
                        wr_data <= {shreg[DATA_W-2:0], bit_i};
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               SQ_SKIP: begin
                  if (cnt == CNT_W'(SKIP_BITS - 1)) begin
                     cnt   <= '0;
                     state <= SQ_HUNT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  state <= SQ_HUNT;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
   import mgmt_pkg::*;
#(
   parameter int NREG          = 32,
   parameter int SYNC_STAGES   = 2,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mdc,
   input  logic                   mdio_i,
   input  logic [ADDR_W-1:0]      phy_addr,
   output logic                   mdio_o,
   output logic                   mdio_oe,
   output logic [NREG*DATA_W-1:0] reg_q
);
   if (NREG < 1 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("NREG must lie between 1 and 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PREAMBLE_BITS < 1) begin : g_bad_pre
      $error("PREAMBLE_BITS must be positive");
   end

   logic              mdc_rise;
   logic              mdio_bit;
   logic [ADDR_W-1:0] reg_idx;
   logic [OP_W-1:0]   op_cur;
   logic [ADDR_W-1:0] dev_cur;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;

   mgmt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .mdc_i  (mdc),
      .mdio_i (mdio_i),
      .rise_o (mdc_rise),
      .bit_o  (mdio_bit)
   );

   mgmt_frame_seq #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (mdc_rise),
      .bit_i   (mdio_bit),
      .strap   (phy_addr),
      .rd_data (rd_data),
      .reg_idx (reg_idx),
      .op_cur  (op_cur),
      .dev_cur (dev_cur),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe)
   );

   mgmt_regfile #(.NREG(NREG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (reg_idx),
      .wr_data   (wr_data),
      .rd_addr   (reg_idx),
      .rd_data   (rd_data),
      .regs_flat (reg_q)
   );
endmodule

// File: rtl/mgmt_phy_responder_chk.sv
module mgmt_phy_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdc_rise,
   input logic       mdio_o,
   input logic       mdio_oe,
   input logic       wr_en,
   input logic [1:0] op_cur,
   input logic [4:0] dev_cur,
   input logic [4:0] phy_addr
);
   p_oe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> $past(mdc_rise));

   p_out_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $past(mdc_rise));

   p_turn_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   p_drive_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> (dev_cur == phy_addr));

   p_drive_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> (op_cur == 2'b10));

   p_write_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (op_cur == 2'b01 && dev_cur == phy_addr));

   p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !mdio_oe);

   p_write_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
endmodule

bind mgmt_phy_responder mgmt_phy_responder_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc_rise (mdc_rise),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .wr_en    (wr_en),
   .op_cur   (op_cur),
   .dev_cur  (dev_cur),
   .phy_addr (phy_addr)
);

// File: tb/mgmt_phy_responder_tb.sv
module mgmt_phy_responder_tb;
   localparam int NREG = 32;
   localparam int SYNC = 3;
   localparam int PRE  = 32;
   localparam int HALF = 8;
   localparam logic [4:0] STRAP = 5'h0B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic m_val = 1'b1;
   logic dut_o, dut_oe;
   logic [NREG*16-1:0] reg_q;
   logic mdio_bus;

   int checks = 0;
   int errors = 0;
   int oe_hits;
   logic last_oe, ta_oe0, ta_oe1, ta_bus1, post_oe;
   logic [15:0] rd_word;
   logic [NREG*16-1:0] pre_commit;

   always #4 clk = ~clk;
   assign mdio_bus = dut_oe ? dut_o : m_val;

   mgmt_phy_responder #(.NREG(NREG), .SYNC_STAGES(SYNC), .PREAMBLE_BITS(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_bus),
      .phy_addr(STRAP), .mdio_o(dut_o), .mdio_oe(dut_oe), .reg_q(reg_q));

   // {op, device, index, write data, expected}
   localparam logic [43:0] VEC [8] = '{
      {2'b01, 5'h0B, 5'd3,  16'hA5C3, 16'hA5C3},
      {2'b10, 5'h0B, 5'd3,  16'h0000, 16'hA5C3},
      {2'b01, 5'h0B, 5'd31, 16'h8001, 16'h8001},
      {2'b10, 5'h0B, 5'd31, 16'h0000, 16'h8001},
      {2'b01, 5'h0A, 5'd3,  16'hFFFF, 16'hA5C3},
      {2'b10, 5'h0B, 5'd3,  16'h0000, 16'hA5C3},
      {2'b10, 5'h0A, 5'd3,  16'h0000, 16'hFFFF},
      {2'b10, 5'h0B, 5'd0,  16'h0000, 16'h0000}
   };

   function automatic logic [15:0] reg_of(input logic [NREG*16-1:0] v, input int i);
      return v[i*16 +: 16];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic mbit(input logic b, output logic s);
      m_val = b;
      repeat (HALF) @(negedge clk);
      s = mdio_bus;
      last_oe = dut_oe;
      if (dut_oe) oe_hits++;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic send_frame(input int pre, input logic [1:0] op, input logic [4:0] dev,
                             input logic [4:0] idx, input logic [15:0] wd);
      logic s;
      logic [15:0] cap;
      cap = '0;
      oe_hits = 0;
      for (int i = 0; i < pre; i++) mbit(1'b1, s);
      mbit(1'b0, s);
      mbit(1'b1, s);
      for (int i = 1; i >= 0; i--) mbit(op[i], s);
      for (int i = 4; i >= 0; i--) mbit(dev[i], s);
      for (int i = 4; i >= 0; i--) mbit(idx[i], s);
      if (op == 2'b01) begin
         mbit(1'b1, s);
         mbit(1'b0, s);
      end else begin
         mbit(1'b1, s); ta_oe0 = last_oe;
         mbit(1'b1, s); ta_oe1 = last_oe; ta_bus1 = s;
      end
      for (int i = 15; i >= 0; i--) begin
         if (op == 2'b01) begin
            if (i == 0) pre_commit = reg_q;
            mbit(wd[i], s);
         end else begin
            mbit(1'b1, s);
            cap[i] = s;
         end
      end
      rd_word = cap;
      m_val = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      post_oe = dut_oe;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic s;
      repeat (5) @(negedge clk);
      chk(dut_oe == 1'b0, "R9 line released in reset", 32'(dut_oe), 0);
      chk(reg_q == '0, "R9 registers cleared in reset", 32'(reg_of(reg_q, 3)), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      foreach (VEC[k]) begin
         logic [1:0] op; logic [4:0] dev, idx; logic [15:0] wd, ex;
         {op, dev, idx, wd, ex} = VEC[k];
         send_frame(PRE, op, dev, idx, wd);
         if (op == 2'b01) begin
            chk(reg_of(reg_q, idx) == ex, "R7/R3 register after write", 32'(reg_of(reg_q, idx)), 32'(ex));
            chk(oe_hits == 0, "R3 no drive on write", oe_hits, 0);
         end else begin
            chk(rd_word == ex, "R2/R5 read data MSB first", 32'(rd_word), 32'(ex));
            if (dev == STRAP) begin
               chk(ta_oe0 == 1'b0, "R5 released in first turnaround bit", 32'(ta_oe0), 0);
               chk(ta_oe1 == 1'b1 && ta_bus1 == 1'b0, "R5 R6 drives 0 in second turnaround bit",
                   {30'b0, ta_oe1, ta_bus1}, 32'h2);
            end else begin
               chk(oe_hits == 0, "R3 mismatched device stays off line", oe_hits, 0);
            end
            chk(post_oe == 1'b0, "R5 released after last data bit", 32'(post_oe), 0);
         end
      end

      // R1: one short of the preamble length
      mbit(1'b0, s);
      send_frame(PRE - 1, 2'b01, STRAP, 5'd5, 16'h1234);
      chk(reg_of(reg_q, 5) == 16'h0000, "R1 short preamble ignored", 32'(reg_of(reg_q, 5)), 0);

      // R1: broken run then a full one
      mbit(1'b0, s);
      for (int i = 0; i < 20; i++) mbit(1'b1, s);
      mbit(1'b0, s);
      send_frame(PRE, 2'b01, STRAP, 5'd5, 16'h1234);
      chk(reg_of(reg_q, 5) == 16'h1234, "R1 full preamble after a break", 32'(reg_of(reg_q, 5)), 32'h1234);

      // R4: unsupported opcodes
      send_frame(PRE, 2'b00, STRAP, 5'd6, 16'h7777);
      chk(reg_of(reg_q, 6) == 16'h0000 && oe_hits == 0, "R4 opcode 00 ignored", 32'(reg_of(reg_q, 6)), 0);
      send_frame(PRE, 2'b11, STRAP, 5'd6, 16'h0000);
      chk(oe_hits == 0 && reg_of(reg_q, 6) == 16'h0000, "R4 opcode 11 ignored", oe_hits, 0);

      // R7: nothing lands before the last data bit
      send_frame(PRE, 2'b01, STRAP, 5'd8, 16'h5A5A);
      chk(reg_of(pre_commit, 8) == 16'h0000, "R7 no partial commit", 32'(reg_of(pre_commit, 8)), 0);
      chk(reg_of(reg_q, 8) == 16'h5A5A, "R7 full commit", 32'(reg_of(reg_q, 8)), 32'h5A5A);

      // R8: frame straight after a frame with no preamble
      send_frame(PRE, 2'b01, STRAP, 5'd7, 16'h00FF);
      send_frame(0, 2'b01, STRAP, 5'd7, 16'hABCD);
      chk(reg_of(reg_q, 7) == 16'h00FF, "R8 back-to-back frame needs preamble", 32'(reg_of(reg_q, 7)), 32'h00FF);
      mbit(1'b0, s);
      send_frame(PRE, 2'b10, STRAP, 5'd7, 16'h0000);
      chk(rd_word == 16'h00FF, "R8 search resumes after a frame", 32'(rd_word), 32'h00FF);

      // R9: reset in service
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(reg_q == '0 && dut_oe == 1'b0, "R9 reset clears registers", 32'(reg_of(reg_q, 3)), 0);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule